// File: doc/BRIEF.md
# Power State and Clock Controller

This block holds the power mode of a display controller core and the settings of its clock generator. The host interface hands it decoded one-byte command codes, a wake strobe (raised when the host performs a dummy read of address zero), and the level of an active-low power-down pin. From these the block chooses one of four modes and drives enables for the core voltage regulator, the crystal oscillator, the PLL and the core clock gate. The regulator, oscillator and PLL are outside the block; it only drives their enables.

Beyond the mode, the block keeps three clock settings. The first picks the PLL reference (internal oscillator or external crystal). The second picks the core frequency (48 MHz or 36 MHz). The third is a one-cycle core reset pulse. A frequency change is held back until a rising frame-sync edge arrives while the pixel divisor is nonzero, so the clock never moves mid-frame. A millisecond tick input times the settle windows after a wake from SLEEP and after the regulator is turned back on. The pin input is assumed to be synchronous to `clk` already.

Top module: `pwr_state_ctl`

## Requirements
- R1: After reset the mode reads STANDBY (`pwr_state`=1). In that mode regulator, oscillator and PLL are on, the core clock is off, `busy`=0, the reference is internal (`pll_src_ext`=0) and 48 MHz is selected (`sel_36m`=0).
- R2: The mode code is 0 for ACTIVE, 1 for STANDBY, 2 for SLEEP and 3 for POWERDOWN. Code 3 is also shown while the block is powering back up. In ACTIVE with `busy` low, code 41h moves to STANDBY, 42h to SLEEP and 50h to POWERDOWN on the next cycle. Outside ACTIVE these three codes are ignored.
- R3: The enables follow the mode. ACTIVE turns all four on, except that the core clock stays off while `busy` is high. STANDBY keeps regulator, oscillator and PLL on. SLEEP keeps only the regulator on. POWERDOWN turns all four off.
- R4: A wake strobe in STANDBY gives ACTIVE on the next cycle with `busy` low and the core clock on.
- R5: A wake strobe in SLEEP gives ACTIVE with `busy` high on the next cycle. `busy` falls on the cycle after the WAKE_MS-th millisecond tick. While it is high the core clock is off and mode commands are ignored.
- R6: `pd_n` low forces POWERDOWN on the next cycle from any mode. This wins over a command or wake strobe in the same cycle. POWERDOWN returns the reference and frequency settings to their reset values and drops any pending frequency request.
- R7: A rising edge of `pd_n` while in POWERDOWN turns on regulator, oscillator and PLL with `busy` high and mode code 3. The block enters STANDBY on the cycle after the BOOT_MS-th tick. Wake strobes do not act during this time.
- R8: Code 44h selects the external reference and 48h the internal one, effective on the next cycle. This works in ACTIVE, STANDBY and SLEEP.
- R9: Code 61h requests 36 MHz (`sel_36m`=1) and 62h requests 48 MHz. A request stays pending and changes `sel_36m` only in the cycle after a rising `vsync` edge seen while `pclk_div_nz` is high. `sel_36m` does not change at any other time.
- R10: Among pending requests the most recent one wins. A request arriving in the same cycle as a qualifying `vsync` edge is applied at that edge.
- R11: Code 68h raises `core_rst` for exactly one cycle, on the cycle after the command.
- R12: Codes not listed in R2, R8, R9 and R11 have no effect. A wake strobe in ACTIVE has no effect.
- R13: While in POWERDOWN or powering up, every command code is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Power-on reset, active low |
| cmd_valid | input | 1 | Command code present this cycle |
| cmd_code | input | 8 | Host command byte |
| wake_req | input | 1 | Wake strobe (dummy read of address zero) |
| pd_n | input | 1 | Power-down pin, active low, synchronous |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| vsync | input | 1 | Frame sync level |
| pclk_div_nz | input | 1 | Pixel clock divisor is nonzero |
| reg_en | output | 1 | Core regulator enable |
| osc_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| core_clk_en | output | 1 | Core clock gate enable |
| pll_src_ext | output | 1 | PLL reference: 1 external, 0 internal |
| sel_36m | output | 1 | Core frequency: 1 for 36 MHz, 0 for 48 MHz |
| core_rst | output | 1 | One-cycle core reset pulse |
| busy | output | 1 | Settle window running |
| pwr_state | output | 2 | Mode code (see R2) |

## Verification
Two pairs of events can land in the same cycle. The first pair is a frequency command and a qualifying `vsync` rise. The bench drives the 61h code on the very cycle `vsync` goes high and expects `sel_36m` to take the new value one cycle later; it also checks that an older pending request is overridden by a newer one. The second pair is the power-down pin falling together with a wake strobe or a reference-select command. There the bench expects POWERDOWN with the reference returned to internal. The bench also sweeps all 256 command codes from ACTIVE against an arithmetic model of mode, reference and reset pulse.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE  = 3'd0,
    ST_STANDBY = 3'd1,
    ST_SLEEP   = 3'd2,
    ST_PDOWN   = 3'd3,
    ST_BOOT    = 3'd4
  } pwr_st_e;

  localparam logic [7:0] OP_STANDBY = 8'h41;
  localparam logic [7:0] OP_SLEEP   = 8'h42;
  localparam logic [7:0] OP_PDOWN   = 8'h50;
  localparam logic [7:0] OP_REF_EXT = 8'h44;
  localparam logic [7:0] OP_REF_INT = 8'h48;
  localparam logic [7:0] OP_F48     = 8'h62;
  localparam logic [7:0] OP_F36     = 8'h61;
  localparam logic [7:0] OP_CRST    = 8'h68;

  typedef struct packed {
    logic to_standby;
    logic to_sleep;
    logic to_pdown;
    logic ref_ext;
    logic ref_int;
    logic f48;
    logic f36;
    logic crst;
  } pwr_op_t;

  function automatic pwr_op_t decode_op(input logic vld, input logic [7:0] code);
    pwr_op_t o;
    o = '0;
    if (vld) begin
      case (code)
        OP_STANDBY: o.to_standby = 1'b1;
        OP_SLEEP:   o.to_sleep   = 1'b1;
        OP_PDOWN:   o.to_pdown   = 1'b1;
        OP_REF_EXT: o.ref_ext    = 1'b1;
        OP_REF_INT: o.ref_int    = 1'b1;
        OP_F48:     o.f48        = 1'b1;
        OP_F36:     o.f36        = 1'b1;
        OP_CRST:    o.crst       = 1'b1;
        default:    o = '0;
      endcase
    end
    return o;
  endfunction

  function automatic logic [1:0] mode_code(input pwr_st_e s);
    logic [2:0] v;
    v = s;
    return (s == ST_BOOT) ? 2'd3 : v[1:0];
  endfunction

endpackage

// File: rtl/pwr_ms_timer.sv
module pwr_ms_timer #(
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          tick,
  output logic          running,
  output logic          done
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (abort)               cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign running = (cnt != '0);
  assign done    = tick && (cnt == TW'(1)) && !abort && !load;

  AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !tick && !abort && !load) |=> running); // R5

endmodule

// File: rtl/pwr_freq_sel.sv
module pwr_freq_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic req_valid,
  input  logic req_36,
  input  logic vsync,
  input  logic div_nz,
  output logic sel_36m,
  output logic commit
);
  logic vs_q, pend_q, pend_val;
  logic vs_edge, nxt_val;

  assign vs_edge = vsync && !vs_q;
  assign nxt_val = req_valid ? req_36 : pend_val;
  assign commit  = vs_edge && div_nz && (req_valid || pend_q) && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vs_q <= 1'b0;
    else        vs_q <= vsync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_36m  <= 1'b0;
      pend_q   <= 1'b0;
      pend_val <= 1'b0;
    end else if (clear) begin
      sel_36m  <= 1'b0;
      pend_q   <= 1'b0;
      pend_val <= 1'b0;
    end else if (commit) begin
      sel_36m  <= nxt_val;
      pend_q   <= 1'b0;
    end else if (req_valid) begin
      pend_q   <= 1'b1;
      pend_val <= req_36;
    end
  end

  AST_FREQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !commit) |=> $stable(sel_36m)); // R9
  AST_FREQ_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ($rose(vsync) && div_nz)); // R9

endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl
  import pwr_ctl_pkg::*;
#(
  parameter int WAKE_MS = 20,
  parameter int BOOT_MS = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  input  logic       wake_req,
  input  logic       pd_n,
  input  logic       ms_tick,
  input  logic       vsync,
  input  logic       pclk_div_nz,
  output logic       reg_en,
  output logic       osc_en,
  output logic       pll_en,
  output logic       core_clk_en,
  output logic       pll_src_ext,
  output logic       sel_36m,
  output logic       core_rst,
  output logic       busy,
  output logic [1:0] pwr_state
);
  localparam int MAX_MS = (WAKE_MS > BOOT_MS) ? WAKE_MS : BOOT_MS;
  localparam int TW     = $clog2(MAX_MS + 1);

  pwr_st_e       st, st_nx;
  pwr_op_t       op;
  logic          pd_q, pd_rise, cfg_ok, freq_clear;
  logic          tmr_load, tmr_done, tmr_run;
  logic [TW-1:0] tmr_val;
  logic          freq_commit;

  assign op      = decode_op(cmd_valid, cmd_code);
  assign pd_rise = pd_n && !pd_q;
  assign cfg_ok  = pd_n && (st != ST_PDOWN) && (st != ST_BOOT);
  assign busy    = tmr_run;

  always_comb begin
    st_nx    = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (!pd_n) begin
      st_nx = ST_PDOWN;
    end else begin
      case (st)
        ST_ACTIVE: begin
          if (!busy) begin
            if (op.to_pdown)        st_nx = ST_PDOWN;
            else if (op.to_sleep)   st_nx = ST_SLEEP;
            else if (op.to_standby) st_nx = ST_STANDBY;
          end
        end
        ST_STANDBY: if (wake_req) st_nx = ST_ACTIVE;
        ST_SLEEP: begin
          if (wake_req) begin
            st_nx    = ST_ACTIVE;
            tmr_load = 1'b1;
            tmr_val  = TW'(WAKE_MS);
          end
        end
        ST_PDOWN: begin
          if (pd_rise) begin
            st_nx    = ST_BOOT;
            tmr_load = 1'b1;
            tmr_val  = TW'(BOOT_MS);
          end
        end
        ST_BOOT:  if (tmr_done) st_nx = ST_STANDBY;
        default:  st_nx = ST_PDOWN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_STANDBY;
      pd_q <= 1'b1;
    end else begin
      st   <= st_nx;
      pd_q <= pd_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    pll_src_ext <= 1'b0;
    else if (st == ST_PDOWN)       pll_src_ext <= 1'b0;
    else if (cfg_ok && op.ref_ext) pll_src_ext <= 1'b1;
    else if (cfg_ok && op.ref_int) pll_src_ext <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) core_rst <= 1'b0;
    else        core_rst <= cfg_ok && op.crst;
  end

  pwr_ms_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort    (!pd_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .tick     (ms_tick),
    .running  (tmr_run),
    .done     (tmr_done)
  );

  assign freq_clear = !pd_n || (st == ST_PDOWN) || (st == ST_BOOT);

  pwr_freq_sel u_freq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (freq_clear),
    .req_valid (cfg_ok && (op.f48 || op.f36)),
    .req_36    (op.f36),
    .vsync     (vsync),
    .div_nz    (pclk_div_nz),
    .sel_36m   (sel_36m),
    .commit    (freq_commit)
  );

  assign reg_en      = (st != ST_PDOWN);
  assign osc_en      = (st == ST_ACTIVE) || (st == ST_STANDBY) || (st == ST_BOOT);
  assign pll_en      = osc_en;
  assign core_clk_en = (st == ST_ACTIVE) && !busy;
  assign pwr_state   = mode_code(st);

  AST_PD_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> (pwr_state == 2'd3 && !core_clk_en)); // R6
  AST_WAKE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STANDBY && wake_req && pd_n) |=> (st == ST_ACTIVE && !busy)); // R4
  AST_WAKE_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SLEEP && wake_req && pd_n) |=> (st == ST_ACTIVE && busy)); // R5
  AST_UNKNOWN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == '0 && !wake_req && pd_n && pd_q && st != ST_BOOT)
      |=> $stable(st)); // R12
  AST_COMMIT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_commit && pd_n) |-> (st != ST_PDOWN)); // R13

endmodule

// File: tb/pwr_state_ctl_test.sv
module pwr_state_ctl_test;
  localparam int WMS = 3;
  localparam int BMS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_code = 8'h00;
  logic wake_req = 1'b0;
  logic pd_n = 1'b1;
  logic ms_tick = 1'b0;
  logic vsync = 1'b0;
  logic pclk_div_nz = 1'b0;
  logic reg_en, osc_en, pll_en, core_clk_en, pll_src_ext, sel_36m, core_rst, busy;
  logic [1:0] pwr_state;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pwr_state_ctl #(.WAKE_MS(WMS), .BOOT_MS(BMS)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .wake_req(wake_req), .pd_n(pd_n), .ms_tick(ms_tick), .vsync(vsync),
    .pclk_div_nz(pclk_div_nz), .reg_en(reg_en), .osc_en(osc_en), .pll_en(pll_en),
    .core_clk_en(core_clk_en), .pll_src_ext(pll_src_ext), .sel_36m(sel_36m),
    .core_rst(core_rst), .busy(busy), .pwr_state(pwr_state)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // enables per mode code: {reg, osc, pll, core}; boot flag selects power-up view
  function automatic logic [3:0] en_model(input int m, input bit bsy, input bit boot);
    if (boot)   return 4'b1110;
    case (m)
      0: return bsy ? 4'b1110 : 4'b1111;
      1: return 4'b1110;
      2: return 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [3:0] en_now();
    return {reg_en, osc_en, pll_en, core_clk_en};
  endfunction

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] c);
    cmd_valid = 1'b1; cmd_code = c;
    cyc();
    cmd_valid = 1'b0; cmd_code = 8'h00;
  endtask

  task automatic wake();
    wake_req = 1'b1; cyc(); wake_req = 1'b0;
  endtask

  task automatic tick();
    ms_tick = 1'b1; cyc(); ms_tick = 1'b0;
  endtask

  task automatic pd_toggle();
    pd_n = 1'b0; cyc(); pd_n = 1'b1; cyc();
  endtask

  task automatic vs_rise();
    vsync = 1'b1; cyc(); vsync = 1'b0; cyc();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic ext_m;
    int exp_st;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    check("R1 mode", pwr_state, 1);
    check("R1 enables", en_now(), en_model(1, 0, 0));
    check("R1 clk cfg", {busy, pll_src_ext, sel_36m, core_rst}, 4'b0000);

    // R4 wake from standby
    wake();
    check("R4 mode", pwr_state, 0);
    check("R4 busy/core", {busy, core_clk_en}, 2'b01);
    // R12 wake in ACTIVE ignored
    wake();
    check("R12 wake in active", {pwr_state, busy}, 3'b000);

    // R2 R8 R11 R12 sweep over every code from ACTIVE
    ext_m = 1'b0;
    for (int c = 0; c < 256; c++) begin
      cmd(c[7:0]);
      exp_st = (c == 8'h41) ? 1 : (c == 8'h42) ? 2 : (c == 8'h50) ? 3 : 0;
      if (c == 8'h44) ext_m = 1'b1;
      if (c == 8'h48 || c == 8'h50) ext_m = 1'b0;
      check($sformatf("R2 R8 R11 R12 code %02h", c),
            {pwr_state, pll_src_ext, core_rst, sel_36m},
            {exp_st[1:0], ext_m, (c == 8'h68), 1'b0});
      if (exp_st == 1) wake();
      else if (exp_st == 2) begin wake(); repeat (WMS) tick(); end
      else if (exp_st == 3) begin pd_toggle(); repeat (BMS) tick(); wake(); end
    end
    // R11 pulse lasts one cycle
    cmd(8'h68);
    cyc();
    check("R11 pulse width", core_rst, 0);

    // R3 R5 sleep and timed wake
    cmd(8'h42);
    check("R3 sleep enables", {pwr_state, en_now()}, {2'd2, en_model(2, 0, 0)});
    cmd(8'h41);
    check("R2 standby code ignored in sleep", pwr_state, 2);
    cmd(8'h44);
    check("R8 ref ext in sleep", pll_src_ext, 1);
    cmd(8'h48);
    wake();
    check("R5 busy after sleep wake", {pwr_state, busy, en_now()}, {2'd0, 1'b1, en_model(0, 1, 0)});
    cmd(8'h41);
    check("R5 mode cmd ignored when busy", pwr_state, 0);
    repeat (WMS - 1) tick();
    check("R5 busy before last tick", busy, 1);
    tick();
    check("R5 busy clears", {busy, core_clk_en}, 2'b01);

    // R9 R10 frequency switching (pending 48 MHz request from sweep)
    cmd(8'h61);
    pclk_div_nz = 1'b0;
    vs_rise();
    check("R9 divisor zero blocks", sel_36m, 0);
    pclk_div_nz = 1'b1;
    repeat (3) cyc();
    check("R9 waits for edge", sel_36m, 0);
    vsync = 1'b1; cyc();
    check("R9 applied at edge", sel_36m, 1);
    vsync = 1'b0; cyc();
    cmd(8'h61); cmd(8'h62);
    vs_rise();
    check("R10 latest request wins", sel_36m, 0);
    vs_rise();
    check("R9 no request no change", sel_36m, 0);
    vsync = 1'b1; cmd_valid = 1'b1; cmd_code = 8'h61; cyc();
    cmd_valid = 1'b0; vsync = 1'b0;
    check("R10 same-cycle request", sel_36m, 1);
    cyc();

    // R6 power-down beats wake and commands, clears settings
    cmd(8'h44);
    cmd(8'h42);
    pd_n = 1'b0; wake_req = 1'b1; cmd_valid = 1'b1; cmd_code = 8'h48; cyc();
    wake_req = 1'b0; cmd_valid = 1'b0;
    check("R6 pd wins", {pwr_state, en_now()}, {2'd3, en_model(3, 0, 0)});
    cyc();
    check("R6 settings cleared", {pll_src_ext, sel_36m}, 2'b00);
    // R13 commands ignored in powerdown (pin held low, then command 50 path)
    pd_n = 1'b1; cyc(); pd_n = 1'b0; cyc();
    // pin still low here; release and check boot
    pd_n = 1'b1; cyc();
    check("R7 boot enables", {pwr_state, busy, en_now()}, {2'd3, 1'b1, en_model(3, 1, 1)});
    cmd(8'h44); wake();
    check("R13 ignored during boot", {pwr_state, pll_src_ext}, 3'b110);
    tick();
    check("R7 still booting", {pwr_state, busy}, 3'b111);
    tick();
    check("R7 reaches standby", {pwr_state, busy, en_now()}, {2'd1, 1'b0, en_model(1, 0, 0)});
    // R13 in powerdown entered by command, pin high: commands and wake ignored
    wake(); cmd(8'h50);
    check("R2 powerdown by command", {pwr_state, en_now()}, {2'd3, 4'b0000});
    cmd(8'h44); cmd(8'h68); wake();
    check("R13 ignored in powerdown", {pwr_state, pll_src_ext, core_rst, reg_en}, 5'b11000);
    // R6 pin during boot aborts timer
    pd_toggle();
    pd_n = 1'b0; cyc(); pd_n = 1'b1;
    check("R6 pin during boot", {pwr_state, busy, reg_en}, 4'b1100);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule